// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block sequences the operating mode of a single-wire bus transceiver among four states: unpowered, fail-safe, normal and sleep. It watches the enable pin from the host controller, qualified wake pulses tagged by where they came from (the bus or a local switch), and three digitized supply comparator flags. From these inputs it drives the mode, the control for the high-side inhibit switch, and the enable for the transmit/receive path. It also drives the two host-facing data pins.

In fail-safe the transmit pin becomes an output. Together with the receive pin it reports a latched 2-bit code that names the event behind the fail-safe entry. Because of that latched code, the controller can tell an undervoltage entry apart from a power-up or wake entry. Only an undervoltage-entered fail-safe may go straight to sleep on an enable falling edge. The delayed transitions are timed with a tick prescaler and a tick counter. Each delay is a parameter given in ticks.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After a synchronous reset the mode is unpowered (mode code 0). In that state inh_on, path_en and txd_oe are 0 and rxd_out is 1. Mode codes are: 0 unpowered, 1 fail-safe, 2 normal, 3 sleep.
- R2: In unpowered with sup_op_ok high, the mode becomes fail-safe on the next clock edge. inh_on and txd_oe are then 1, and the code is none (txd_out=1, rxd_out=1).
- R3: In fail-safe, a synchronized enable high together with sup_uv_ok high moves the mode to normal. The change happens exactly SYNC_STAGES+1+NORM_TICKS*TICK_DIV clock edges after the enable pin rises. With sup_uv_ok low, no move happens. The latched cause is cleared on entry to normal.
- R4: In normal, an enable falling edge moves the mode to sleep exactly SYNC_STAGES+1+SLEEP_TICKS*TICK_DIV edges after the pin falls. In sleep, inh_on is 0.
- R5: In normal with sup_uv_low high, the mode becomes fail-safe on the next edge and the code is undervoltage (txd_out=1, rxd_out=0).
- R6: In a fail-safe entered through undervoltage, an enable falling edge moves the mode to sleep after the sleep delay of R4. In a fail-safe with any other cause, an enable falling edge leaves the mode in fail-safe.
- R7: In sleep, a wake_pulse moves the mode to fail-safe on the next edge. With wake_is_local=0 the code is bus wake (txd_out=0, rxd_out=0). With wake_is_local=1 the code is local wake (txd_out=0, rxd_out=1).
- R8: In sleep, sup_uv_low high causes no mode change.
- R9: With sup_op_ok low, any mode becomes unpowered on the next edge, and inh_on drops.
- R10: In sleep, a synchronized enable high with sup_uv_ok high moves the mode to normal exactly SYNC_STAGES+1+WAKE_TICKS*TICK_DIV edges after the enable pin rises.
- R11: An enable falling edge while the fail-safe-to-normal delay is pending cancels it, and the mode stays fail-safe.
- R12: path_en is 1 only in normal, and there rxd_out follows bus_rx. txd_oe is 1 only in fail-safe. Outside fail-safe and normal, rxd_out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_pin | input | 1 | Asynchronous enable request from the host |
| wake_pulse | input | 1 | One-cycle qualified wake event |
| wake_is_local | input | 1 | Wake source tag: 1 local switch, 0 bus |
| sup_op_ok | input | 1 | Supply above the operation threshold |
| sup_uv_low | input | 1 | Supply below the falling undervoltage threshold |
| sup_uv_ok | input | 1 | Supply above the rising undervoltage threshold |
| bus_rx | input | 1 | Digitized bus level, 1 = recessive |
| mode | output | 2 | Current mode code (see R1) |
| inh_on | output | 1 | Inhibit high-side switch control |
| path_en | output | 1 | Transmit/receive path enable |
| txd_oe | output | 1 | Transmit pin driven as an output |
| txd_out | output | 1 | Value on the transmit pin when txd_oe is 1 |
| rxd_out | output | 1 | Receive pin value |

## Verification
The bench builds the block with TICK_DIV=4, NORM_TICKS=3, SLEEP_TICKS=2 and WAKE_TICKS=5, keeping SYNC_STAGES=2. The three delays then last 15, 11 and 23 edges from the pin change. That makes it cheap to sample each transition one edge before and at the edge where it is due, and to land a cancelling falling edge inside the pending window. The short delays also leave room to walk every mode and every fail-safe cause in one run.

// File: rtl/xcvr_mode_pkg.sv
// Shared types for the transceiver mode controller.
// Assumes a 2-bit mode code and a 2-bit pin code {txd, rxd}.
package xcvr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_FAIL   = 2'd1,
        MODE_NORMAL = 2'd2,
        MODE_SLEEP  = 2'd3
    } xmode_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_BUS   = 2'd1,
        CAUSE_LOCAL = 2'd2,
        CAUSE_UV    = 2'd3
    } xcause_t;

    // Pin code {txd, rxd} reported in fail-safe for each cause.
    function automatic logic [1:0] cause_pins(xcause_t c);
        case (c)
            CAUSE_BUS:   cause_pins = 2'b00;
            CAUSE_LOCAL: cause_pins = 2'b01;
            CAUSE_UV:    cause_pins = 2'b10;
            default:     cause_pins = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/xcvr_en_sync.sv
// Enable input synchronizer with falling-edge detect.
// Assumes STAGES >= 2; the edge is taken from the synchronized level.
module xcvr_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // One flop of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else if (i == 0) chain_q[i] <= din;
                else chain_q[i] <= chain_q[(i > 0) ? i - 1 : 0];
            end
        end
    endgenerate

    // Previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign fall  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_tick_timer.sv
// Mode-change delay timer: a prescaler of TICK_DIV cycles and a tick count.
// A start loads TICKS (>= 1); done pulses for one cycle TICKS*TICK_DIV cycles
// after the start edge. Start wins over cancel; the timer idles after done.
module xcvr_tick_timer #(
    parameter int TICK_DIV = 100,
    parameter int TW       = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cancel,
    input  logic [TW-1:0] ticks,
    output logic          done
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

    logic          busy_q;
    logic [PW-1:0] pre_q;
    logic [TW-1:0] cnt_q;

    assign done = busy_q && (pre_q == PRE_LAST) && (cnt_q == '0);

    // Load, cancel or count the pending delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pre_q  <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            pre_q  <= '0;
            cnt_q  <= ticks - TW'(1);
        end else if (cancel || done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q - TW'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/xcvr_cause_latch.sv
// Holds the event behind the latest fail-safe entry.
// Assumes at most one set request per cycle; clear has priority.
module xcvr_cause_latch
    import xcvr_mode_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    set_bus,
    input  logic    set_local,
    input  logic    set_uv,
    output xcause_t cause
);
    // Update the latched cause.
    always_ff @(posedge clk) begin
        if (!rst_n)         cause <= CAUSE_NONE;
        else if (clr)       cause <= CAUSE_NONE;
        else if (set_uv)    cause <= CAUSE_UV;
        else if (set_bus)   cause <= CAUSE_BUS;
        else if (set_local) cause <= CAUSE_LOCAL;
    end
endmodule

// File: rtl/xcvr_mode_fsm.sv
// Four-state mode sequencer. Supply loss has top priority; immediate moves
// (undervoltage, wake) override a pending delayed move. Assumes the supply
// flags and wake pulse are already synchronous to clk.
module xcvr_mode_fsm
    import xcvr_mode_pkg::*;
#(
    parameter int TW          = 9,
    parameter int NORM_TICKS  = 15,
    parameter int SLEEP_TICKS = 15,
    parameter int WAKE_TICKS  = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_lvl,
    input  logic          en_fall,
    input  logic          wake_pulse,
    input  logic          wake_is_local,
    input  logic          op_ok,
    input  logic          uv_low,
    input  logic          uv_ok,
    input  xcause_t       cause,
    input  logic          tmr_done,
    output xmode_t        mode,
    output logic          tmr_start,
    output logic          tmr_cancel,
    output logic [TW-1:0] tmr_ticks,
    output logic          clr_cause,
    output logic          set_bus,
    output logic          set_local,
    output logic          set_uv
);
    xmode_t nxt_mode, tgt_q, nxt_tgt;
    logic   pend_q, nxt_pend;

    // Next-state and timer/cause control decode.
    always_comb begin
        nxt_mode   = mode;
        nxt_pend   = pend_q;
        nxt_tgt    = tgt_q;
        tmr_start  = 1'b0;
        tmr_cancel = 1'b0;
        tmr_ticks  = TW'(NORM_TICKS);
        clr_cause  = 1'b0;
        set_bus    = 1'b0;
        set_local  = 1'b0;
        set_uv     = 1'b0;
        if (!op_ok) begin
            nxt_mode   = MODE_OFF;
            nxt_pend   = 1'b0;
            tmr_cancel = 1'b1;
            clr_cause  = 1'b1;
        end else begin
            case (mode)
                MODE_OFF: begin
                    nxt_mode  = MODE_FAIL;
                    clr_cause = 1'b1;
                end
                MODE_FAIL: begin
                    if (en_fall) begin
                        tmr_cancel = 1'b1;
                        nxt_pend   = 1'b0;
                        if (cause == CAUSE_UV) begin
                            tmr_start = 1'b1;
                            tmr_ticks = TW'(SLEEP_TICKS);
                            nxt_pend  = 1'b1;
                            nxt_tgt   = MODE_SLEEP;
                        end
                    end else if (pend_q && tmr_done) begin
                        nxt_mode  = tgt_q;
                        nxt_pend  = 1'b0;
                        clr_cause = (tgt_q == MODE_NORMAL);
                    end else if (!pend_q && en_lvl && uv_ok) begin
                        tmr_start = 1'b1;
                        tmr_ticks = TW'(NORM_TICKS);
                        nxt_pend  = 1'b1;
                        nxt_tgt   = MODE_NORMAL;
                    end
                end
                MODE_NORMAL: begin
                    if (uv_low) begin
                        nxt_mode   = MODE_FAIL;
                        nxt_pend   = 1'b0;
                        tmr_cancel = 1'b1;
                        set_uv     = 1'b1;
                    end else if (pend_q && tmr_done) begin
                        nxt_mode = tgt_q;
                        nxt_pend = 1'b0;
                    end else if (!pend_q && en_fall) begin
                        tmr_start = 1'b1;
                        tmr_ticks = TW'(SLEEP_TICKS);
                        nxt_pend  = 1'b1;
                        nxt_tgt   = MODE_SLEEP;
                    end
                end
                default: begin // MODE_SLEEP
                    if (wake_pulse) begin
                        nxt_mode   = MODE_FAIL;
                        nxt_pend   = 1'b0;
                        tmr_cancel = 1'b1;
                        set_bus    = ~wake_is_local;
                        set_local  = wake_is_local;
                    end else if (en_fall) begin
                        tmr_cancel = 1'b1;
                        nxt_pend   = 1'b0;
                    end else if (pend_q && tmr_done) begin
                        nxt_mode  = tgt_q;
                        nxt_pend  = 1'b0;
                        clr_cause = 1'b1;
                    end else if (!pend_q && en_lvl && uv_ok) begin
                        tmr_start = 1'b1;
                        tmr_ticks = TW'(WAKE_TICKS);
                        nxt_pend  = 1'b1;
                        nxt_tgt   = MODE_NORMAL;
                    end
                end
            endcase
        end
    end

    // Mode, pending flag and pending target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_OFF;
            pend_q <= 1'b0;
            tgt_q  <= MODE_NORMAL;
        end else begin
            mode   <= nxt_mode;
            pend_q <= nxt_pend;
            tgt_q  <= nxt_tgt;
        end
    end
endmodule

// File: rtl/xcvr_mode_ctrl.sv
// Top of the transceiver mode controller: synchronizes enable, sequences the
// mode, times the delayed moves and decodes the pin and switch controls.
// Delays are given in ticks of TICK_DIV clock cycles.
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TICK_DIV    = 100,
    parameter int NORM_TICKS  = 15,
    parameter int SLEEP_TICKS = 15,
    parameter int WAKE_TICKS  = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin,
    input  logic       wake_pulse,
    input  logic       wake_is_local,
    input  logic       sup_op_ok,
    input  logic       sup_uv_low,
    input  logic       sup_uv_ok,
    input  logic       bus_rx,
    output logic [1:0] mode,
    output logic       inh_on,
    output logic       path_en,
    output logic       txd_oe,
    output logic       txd_out,
    output logic       rxd_out
);
    localparam int MAX_A     = (NORM_TICKS > SLEEP_TICKS) ? NORM_TICKS : SLEEP_TICKS;
    localparam int MAX_TICKS = (MAX_A > WAKE_TICKS) ? MAX_A : WAKE_TICKS;
    localparam int TW        = $clog2(MAX_TICKS + 1);

    logic          en_lvl, en_fall;
    logic          tmr_start, tmr_cancel, tmr_done;
    logic [TW-1:0] tmr_ticks;
    logic          clr_cause, set_bus, set_local, set_uv;
    xcause_t       cause_q;
    xmode_t        mode_q;
    logic [1:0]    pins;

    xcvr_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(en_pin),
        .level(en_lvl), .fall(en_fall)
    );

    xcvr_tick_timer #(.TICK_DIV(TICK_DIV), .TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .cancel(tmr_cancel),
        .ticks(tmr_ticks), .done(tmr_done)
    );

    xcvr_cause_latch u_cause (
        .clk(clk), .rst_n(rst_n), .clr(clr_cause), .set_bus(set_bus),
        .set_local(set_local), .set_uv(set_uv), .cause(cause_q)
    );

    xcvr_mode_fsm #(
        .TW(TW), .NORM_TICKS(NORM_TICKS), .SLEEP_TICKS(SLEEP_TICKS),
        .WAKE_TICKS(WAKE_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_lvl(en_lvl), .en_fall(en_fall),
        .wake_pulse(wake_pulse), .wake_is_local(wake_is_local),
        .op_ok(sup_op_ok), .uv_low(sup_uv_low), .uv_ok(sup_uv_ok),
        .cause(cause_q), .tmr_done(tmr_done), .mode(mode_q),
        .tmr_start(tmr_start), .tmr_cancel(tmr_cancel), .tmr_ticks(tmr_ticks),
        .clr_cause(clr_cause), .set_bus(set_bus), .set_local(set_local),
        .set_uv(set_uv)
    );

    // Output decode from the registered mode and latched cause.
    always_comb begin
        pins    = cause_pins(cause_q);
        mode    = mode_q;
        inh_on  = (mode_q == MODE_FAIL) || (mode_q == MODE_NORMAL);
        path_en = (mode_q == MODE_NORMAL);
        txd_oe  = (mode_q == MODE_FAIL);
        txd_out = (mode_q == MODE_FAIL) ? pins[1] : 1'b0;
        case (mode_q)
            MODE_NORMAL: rxd_out = bus_rx;
            MODE_FAIL:   rxd_out = pins[0];
            default:     rxd_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/xcvr_mode_chk.sv
// Property checker for the mode controller, bound to the top module.
module xcvr_mode_chk
    import xcvr_mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_ok,
    input logic       uv_low,
    input logic       wake_pulse,
    input logic       wake_is_local,
    input logic [1:0] mode,
    input logic       inh_on,
    input logic       path_en,
    input logic       txd_oe,
    input logic       txd_out,
    input logic       rxd_out,
    input xcause_t    cause,
    input logic       tmr_done
);
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (mode == MODE_OFF && !inh_on && !txd_oe));

    p_powerup_fs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && op_ok) |=> (mode == MODE_FAIL && txd_out && rxd_out));

    p_normal_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL) |-> (cause == CAUSE_NONE));

    p_uv_to_fs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && op_ok && uv_low) |=>
            (mode == MODE_FAIL && txd_out && !rxd_out));

    p_wake_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && op_ok && wake_pulse) |=>
            (mode == MODE_FAIL && !txd_out && rxd_out == $past(wake_is_local)));

    p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && op_ok && !wake_pulse && !tmr_done) |=>
            (mode == MODE_SLEEP));

    p_op_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_ok |=> (mode == MODE_OFF && !inh_on));

    p_paths_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (path_en |-> !txd_oe) and (txd_oe |-> inh_on));
endmodule

bind xcvr_mode_ctrl xcvr_mode_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_ok(sup_op_ok), .uv_low(sup_uv_low),
    .wake_pulse(wake_pulse), .wake_is_local(wake_is_local), .mode(mode),
    .inh_on(inh_on), .path_en(path_en), .txd_oe(txd_oe), .txd_out(txd_out),
    .rxd_out(rxd_out), .cause(cause_q), .tmr_done(tmr_done)
);

// File: tb/tb_xcvr_mode_ctrl.sv
// Directed bench for the transceiver mode controller.
module tb_xcvr_mode_ctrl;
    localparam int SYNC = 2, DIV = 4, NT = 3, ST = 2, WT = 5;
    localparam int LN = SYNC + 1 + NT * DIV;
    localparam int LS = SYNC + 1 + ST * DIV;
    localparam int LW = SYNC + 1 + WT * DIV;
    localparam logic [1:0] M_OFF = 2'd0, M_FS = 2'd1, M_NORM = 2'd2, M_SLP = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en_pin = 1'b0, wake_pulse = 1'b0, wake_is_local = 1'b0;
    logic sup_op_ok = 1'b0, sup_uv_low = 1'b0, sup_uv_ok = 1'b1, bus_rx = 1'b1;
    logic [1:0] mode;
    logic inh_on, path_en, txd_oe, txd_out, rxd_out;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xcvr_mode_ctrl #(.SYNC_STAGES(SYNC), .TICK_DIV(DIV), .NORM_TICKS(NT),
                     .SLEEP_TICKS(ST), .WAKE_TICKS(WT)) dut (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .wake_pulse(wake_pulse),
        .wake_is_local(wake_is_local), .sup_op_ok(sup_op_ok),
        .sup_uv_low(sup_uv_low), .sup_uv_ok(sup_uv_ok), .bus_rx(bus_rx),
        .mode(mode), .inh_on(inh_on), .path_en(path_en), .txd_oe(txd_oe),
        .txd_out(txd_out), .rxd_out(rxd_out)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Packed observation {mode, inh, path, oe, txd, rxd}
    function automatic logic [7:0] obs();
        return {1'b0, mode, inh_on, path_en, txd_oe, txd_out, rxd_out};
    endfunction

    function automatic logic [7:0] fs_exp(input logic [1:0] code);
        return {1'b0, M_FS, 1'b1, 1'b0, 1'b1, code};
    endfunction

    task automatic t_reset();
        step(3);
        check("R1 reset state", obs(), {1'b0, M_OFF, 4'b0000, 1'b1});
        rst_n = 1'b1;
    endtask

    task automatic t_powerup();
        sup_op_ok = 1'b1;
        step(1);
        check("R2 power-up to fail-safe code none", obs(), fs_exp(2'b11));
    endtask

    task automatic t_no_uv_ok();
        sup_uv_ok = 1'b0;
        en_pin = 1'b1;
        step(LN + 5);
        check("R3 no move without uv_ok", {6'd0, mode}, {6'd0, M_FS});
        en_pin = 1'b0;
        step(6);
        check("R6 enable fall in non-uv fail-safe holds", obs(), fs_exp(2'b11));
        sup_uv_ok = 1'b1;
    endtask

    task automatic t_to_normal();
        en_pin = 1'b1;
        step(LN - 1);
        check("R3 fail-safe before delay", {6'd0, mode}, {6'd0, M_FS});
        step(1);
        check("R3 normal at delay", {6'd0, mode}, {6'd0, M_NORM});
        check("R12 normal outputs", {4'd0, inh_on, path_en, txd_oe, txd_out}, 8'b0000_1100);
    endtask

    task automatic t_rx_follow();
        bus_rx = 1'b0; #1;
        check("R12 rxd follows bus low", {7'd0, rxd_out}, 8'd0);
        bus_rx = 1'b1; #1;
        check("R12 rxd follows bus high", {7'd0, rxd_out}, 8'd1);
    endtask

    task automatic t_to_sleep();
        en_pin = 1'b0;
        step(LS - 1);
        check("R4 normal before sleep delay", {6'd0, mode}, {6'd0, M_NORM});
        step(1);
        check("R4 sleep at delay", obs(), {1'b0, M_SLP, 4'b0000, 1'b1});
    endtask

    task automatic t_sleep_uv();
        sup_uv_low = 1'b1;
        step(4);
        check("R8 undervoltage in sleep no change", {6'd0, mode}, {6'd0, M_SLP});
        sup_uv_low = 1'b0;
    endtask

    task automatic t_wake(input logic local_src);
        wake_is_local = local_src;
        wake_pulse = 1'b1;
        step(1);
        wake_pulse = 1'b0;
        check(local_src ? "R7 local wake code" : "R7 bus wake code", obs(),
              fs_exp({1'b0, local_src}));
    endtask

    task automatic t_uv_normal();
        sup_uv_ok = 1'b0;
        sup_uv_low = 1'b1;
        step(1);
        check("R5 undervoltage to fail-safe code", obs(), fs_exp(2'b10));
        sup_uv_low = 1'b0;
        step(3);
    endtask

    task automatic t_uv_fs_sleep();
        en_pin = 1'b0;
        step(LS - 1);
        check("R6 uv fail-safe before sleep delay", {6'd0, mode}, {6'd0, M_FS});
        step(1);
        check("R6 uv fail-safe to sleep", {6'd0, mode}, {6'd0, M_SLP});
        sup_uv_ok = 1'b1;
    endtask

    task automatic t_cancel();
        en_pin = 1'b1;
        step(5);
        en_pin = 1'b0;
        step(LN + 5);
        check("R11 pending normal cancelled", obs(), fs_exp(2'b01));
    endtask

    task automatic t_sleep_to_normal();
        en_pin = 1'b1;
        step(LW - 1);
        check("R10 sleep before wake delay", {6'd0, mode}, {6'd0, M_SLP});
        step(1);
        check("R10 normal after wake delay", {6'd0, mode}, {6'd0, M_NORM});
    endtask

    task automatic t_op_loss();
        sup_op_ok = 1'b0;
        step(1);
        check("R9 supply loss to unpowered", obs(), {1'b0, M_OFF, 4'b0000, 1'b1});
        sup_op_ok = 1'b1;
        en_pin = 1'b0;
        step(1);
        check("R2 re-power to fail-safe", obs(), fs_exp(2'b11));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_powerup();
        t_no_uv_ok();
        t_to_normal();
        t_rx_follow();
        t_to_sleep();
        t_sleep_uv();
        t_wake(1'b0);
        t_to_normal();
        t_uv_normal();
        t_uv_fs_sleep();
        t_wake(1'b1);
        t_cancel();
        t_to_normal();
        t_to_sleep();
        t_sleep_to_normal();
        t_op_loss();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule